// File: doc/BRIEF.md
# Flash self-programming command controller

This block sits between a processor and its program-memory array and turns a two-step software sequence into one flash operation. Software first writes a five-bit command into a small control register. A legal command arms the block for a short window of clock edges. Within that window, a store request supplies a 16-bit pointer and a 16-bit data word. The block decodes the armed command and issues one of five flash operations:

- a temporary page-buffer fill,
- a page erase,
- a page write,
- a lock-bit set,
- a re-enable of the read-while-write section.

Erase and write are long operations. For these the block latches the page address and holds its busy output for a parameterised number of cycles. It then gives a one-cycle done pulse. If the page lies at or above the no-read-while-write boundary page, it also stalls the processor for the whole operation.

The controller is a three-state machine.

- IDLE: nothing is armed.
- ARMED: a command waits for a store request.
- BUSY: an erase or write is running.

The transitions are:

- arm: IDLE to ARMED, on a legal register write.
- rearm: ARMED to ARMED, on a legal register write inside the window.
- lapse: ARMED to IDLE, when the window runs out.
- issue: ARMED to IDLE, on a store request for a single-cycle operation.
- launch: ARMED to BUSY, on a store request for an erase or write.
- finish: BUSY to IDLE, when the duration counter expires.

Control-register bits are: bit0 enable, bit1 erase select, bit2 write select, bit3 lock-bit select, bit4 read-while-write re-enable. The pointer is a byte address. With the default 32-word page, bits 5:1 select the word within the page and bits 15:6 select the page. Bit 0 is never used.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A register write of one of the legal patterns 00001, 00011, 00101, 01001 or 10001 while idle shows that pattern on `ctl_bits` from the next cycle. A store request on any of the next four rising edges after the write is accepted and gives a one-cycle `fl_valid`.
- R2: If no store request arrives by the fourth edge after the arming write, `ctl_bits` returns to 00000. A later store request produces no `fl_valid`.
- R3: A register write of any other pattern is ignored. When idle, `ctl_bits` stays 00000. When armed, the armed pattern stays and the window keeps counting from the original write.
- R4: A legal register write while armed replaces the armed pattern and restarts the four-edge window. If a store request arrives on the same edge, the store request wins and the register write is dropped.
- R5: Pattern 00001 issues `fl_cmd` = 1 (buffer fill). `fl_word` is pointer bits 5:1, `fl_page` is 0 and `fl_data` is the data word. Pointer bit 0 has no effect. `ctl_bits` returns to 00000 and `busy` stays low.
- R6: Pattern 00011 issues `fl_cmd` = 2 (page erase) with `fl_data` = 0 and `fl_word` = 0. `busy` is then high for exactly ERASE_CYCLES cycles, during which `ctl_bits` stays 00011.
- R7: Pattern 00101 issues `fl_cmd` = 3 (page write) with `fl_data` = 0 and `fl_word` = 0. `busy` is then high for exactly WRITE_CYCLES cycles, during which `ctl_bits` stays 00101.
- R8: On the cycle `busy` falls, `done` is high for exactly one cycle and `ctl_bits` reads 00000.
- R9: For erase and write, `fl_page` is pointer bits 15:6 at the accepting edge. It holds that value for the whole busy period, whatever the pointer does afterwards.
- R10: Pattern 01001 issues `fl_cmd` = 4 (lock-bit set) with `fl_page` = 0 and `fl_word` = 0 for any pointer, and `fl_data` equal to the data word.
- R11: Pattern 10001 issues `fl_cmd` = 5 (read-while-write re-enable) with `fl_page`, `fl_word` and `fl_data` all 0.
- R12: While busy, register writes and store requests have no effect. `ctl_bits` is unchanged and no `fl_valid` is raised.
- R13: `cpu_stall` is high during the busy period exactly when the latched page is at or above NRWW_PAGE, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control-register write strobe |
| reg_wdata | input | 5 | Command pattern written to the control register |
| ctl_bits | output | 5 | Current control-register contents |
| st_req | input | 1 | Store-request strobe |
| st_ptr | input | PTR_W (16) | Byte pointer for the store request |
| st_data | input | DATA_W (16) | Data word for the store request |
| fl_valid | output | 1 | One-cycle strobe: a flash command is presented |
| fl_cmd | output | 3 | Flash command code (1 fill, 2 erase, 3 write, 4 lock, 5 re-enable) |
| fl_page | output | PAGE_W (10) | Page number; held through erase and write |
| fl_word | output | WORD_W (5) | Word within page for a buffer fill |
| fl_data | output | DATA_W (16) | Data word for fill or lock-bit set |
| busy | output | 1 | Erase or write in progress |
| done | output | 1 | One-cycle pulse when an erase or write completes |
| cpu_stall | output | 1 | Processor stall for operations on no-read-while-write pages |

## Verification
A window counter that is off by one shows up at the ports within five cycles of an arming write. A store request on the fourth edge either wrongly misses `fl_valid` or wrongly raises it on the fifth. A corrupted command register shows on `ctl_bits` the cycle after the write, and on `fl_cmd` the cycle after the store request. A wrong duration count, a lost page latch or a wrong boundary compare is visible during the busy period itself: `busy` runs too long or too short, `fl_page` moves when the pointer is changed, or `cpu_stall` disagrees with the page. `done` and `ctl_bits` then expose a bad completion on the single cycle `busy` falls.

// File: rtl/fcc_pkg.sv
`timescale 1ns/1ps
package fcc_pkg;

    localparam int CMD_W = 5;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_BUSY  = 2'd2
    } fcc_state_e;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_FILL  = 3'd1,
        OP_ERASE = 3'd2,
        OP_WRITE = 3'd3,
        OP_LOCK  = 3'd4,
        OP_RWWEN = 3'd5
    } fcc_op_e;

endpackage

// File: rtl/fcc_decode.sv
`timescale 1ns/1ps
// Maps a five-bit command pattern to an operation; anything else is illegal.
module fcc_decode
    import fcc_pkg::*;
(
    input  logic [CMD_W-1:0] bits,
    output logic             legal,
    output fcc_op_e          op
);

    always_comb begin
        legal = 1'b1;
        unique case (bits)
            5'b00001: op = OP_FILL;
            5'b00011: op = OP_ERASE;
            5'b00101: op = OP_WRITE;
            5'b01001: op = OP_LOCK;
            5'b10001: op = OP_RWWEN;
            default: begin
                op    = OP_NONE;
                legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fcc_ptr_split.sv
`timescale 1ns/1ps
// Splits a byte pointer into word-in-page and page fields and flags
// pages at or above the no-read-while-write boundary.
module fcc_ptr_split #(
    parameter int PTR_W      = 16,
    parameter int PAGE_WORDS = 32,
    parameter int NRWW_PAGE  = 960,
    localparam int WORD_W    = $clog2(PAGE_WORDS),
    localparam int PAGE_W    = PTR_W - 1 - WORD_W
) (
    input  logic [PTR_W-1:0]  ptr,
    output logic [WORD_W-1:0] word,
    output logic [PAGE_W-1:0] page,
    output logic              in_nrww
);

    assign word = ptr[WORD_W:1];
    assign page = ptr[PTR_W-1:WORD_W+1];

    generate
        if (NRWW_PAGE == 0) begin : g_all_nrww
            assign in_nrww = 1'b1;
        end else begin : g_cmp_nrww
            assign in_nrww = (32'(page) >= 32'(NRWW_PAGE));
        end
    endgenerate

endmodule

// File: rtl/fcc_window.sv
`timescale 1ns/1ps
// Counts the edges since the arming write; last is high on the final edge
// of the acceptance window.
module fcc_window #(
    parameter int WINDOW = 4,
    localparam int CW    = (WINDOW > 1) ? $clog2(WINDOW) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic last
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    assign last = run && (cnt == CW'(WINDOW - 1));

endmodule

// File: rtl/fcc_op_timer.sv
`timescale 1ns/1ps
// Models the duration of an erase or write with a down counter.
module fcc_op_timer #(
    parameter int ERASE_CYCLES = 40,
    parameter int WRITE_CYCLES = 32,
    localparam int MAXC        = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES,
    localparam int TW          = $clog2(MAXC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_write,
    input  logic run,
    output logic expired
);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= sel_write ? TW'(WRITE_CYCLES - 1) : TW'(ERASE_CYCLES - 1);
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && (cnt == '0);

endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
// Flash self-programming command controller: arm / accept / run sequencer.
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int PTR_W        = 16,
    parameter int DATA_W       = 16,
    parameter int PAGE_WORDS   = 32,
    parameter int NRWW_PAGE    = 960,
    parameter int ERASE_CYCLES = 40,
    parameter int WRITE_CYCLES = 32,
    parameter int WINDOW       = 4,
    localparam int WORD_W      = $clog2(PAGE_WORDS),
    localparam int PAGE_W      = PTR_W - 1 - WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [4:0]        reg_wdata,
    output logic [4:0]        ctl_bits,
    input  logic              st_req,
    input  logic [PTR_W-1:0]  st_ptr,
    input  logic [DATA_W-1:0] st_data,
    output logic              fl_valid,
    output logic [2:0]        fl_cmd,
    output logic [PAGE_W-1:0] fl_page,
    output logic [WORD_W-1:0] fl_word,
    output logic [DATA_W-1:0] fl_data,
    output logic              busy,
    output logic              done,
    output logic              cpu_stall
);

    fcc_state_e       state, state_d;
    logic [CMD_W-1:0] ctl_q, ctl_d;
    logic             nrww_q;

    logic             wr_legal;
    fcc_op_e          wr_op;
    logic             arm_legal;
    fcc_op_e          arm_op;
    logic             win_restart, win_last;
    logic             accept, long_op, tmr_load, tmr_expired, finish;
    logic [WORD_W-1:0] sp_word;
    logic [PAGE_W-1:0] sp_page;
    logic             sp_nrww;

    fcc_decode u_wr_dec (
        .bits  (reg_wdata),
        .legal (wr_legal),
        .op    (wr_op)
    );

    fcc_decode u_arm_dec (
        .bits  (ctl_q),
        .legal (arm_legal),
        .op    (arm_op)
    );

    fcc_ptr_split #(
        .PTR_W      (PTR_W),
        .PAGE_WORDS (PAGE_WORDS),
        .NRWW_PAGE  (NRWW_PAGE)
    ) u_split (
        .ptr     (st_ptr),
        .word    (sp_word),
        .page    (sp_page),
        .in_nrww (sp_nrww)
    );

    fcc_window #(.WINDOW(WINDOW)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (win_restart),
        .run     (state == S_ARMED),
        .last    (win_last)
    );

    fcc_op_timer #(
        .ERASE_CYCLES (ERASE_CYCLES),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tmr_load),
        .sel_write (arm_op == OP_WRITE),
        .run       (state == S_BUSY),
        .expired   (tmr_expired)
    );

    assign long_op = (arm_op == OP_ERASE) || (arm_op == OP_WRITE);

    // Transition logic: arm, rearm, lapse, issue, launch, finish.
    always_comb begin
        state_d     = state;
        ctl_d       = ctl_q;
        win_restart = 1'b0;
        accept      = 1'b0;
        tmr_load    = 1'b0;
        finish      = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (reg_we && wr_legal) begin
                    state_d     = S_ARMED;
                    ctl_d       = reg_wdata;
                    win_restart = 1'b1;
                end
            end
            S_ARMED: begin
                if (st_req && arm_legal) begin
                    accept = 1'b1;
                    if (long_op) begin
                        state_d  = S_BUSY;
                        tmr_load = 1'b1;
                    end else begin
                        state_d = S_IDLE;
                        ctl_d   = '0;
                    end
                end else if (reg_we && wr_legal) begin
                    ctl_d       = reg_wdata;
                    win_restart = 1'b1;
                end else if (win_last) begin
                    state_d = S_IDLE;
                    ctl_d   = '0;
                end
            end
            S_BUSY: begin
                if (tmr_expired) begin
                    state_d = S_IDLE;
                    ctl_d   = '0;
                    finish  = 1'b1;
                end
            end
            default: begin
                state_d = S_IDLE;
                ctl_d   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            ctl_q <= '0;
        end else begin
            state <= state_d;
            ctl_q <= ctl_d;
        end
    end

    // Command issue register: fields are captured only on acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_valid <= 1'b0;
            fl_cmd   <= '0;
            fl_page  <= '0;
            fl_word  <= '0;
            fl_data  <= '0;
            nrww_q   <= 1'b0;
            done     <= 1'b0;
        end else begin
            fl_valid <= accept;
            done     <= finish;
            if (accept) begin
                fl_cmd <= arm_op;
                unique case (arm_op)
                    OP_FILL: begin
                        fl_page <= '0;
                        fl_word <= sp_word;
                        fl_data <= st_data;
                        nrww_q  <= 1'b0;
                    end
                    OP_ERASE, OP_WRITE: begin
                        fl_page <= sp_page;
                        fl_word <= '0;
                        fl_data <= '0;
                        nrww_q  <= sp_nrww;
                    end
                    OP_LOCK: begin
                        fl_page <= '0;
                        fl_word <= '0;
                        fl_data <= st_data;
                        nrww_q  <= 1'b0;
                    end
                    default: begin
                        fl_page <= '0;
                        fl_word <= '0;
                        fl_data <= '0;
                        nrww_q  <= 1'b0;
                    end
                endcase
            end
        end
    end

    // Port outputs derived from state.
    always_comb begin
        ctl_bits  = ctl_q;
        busy      = (state == S_BUSY);
        cpu_stall = (state == S_BUSY) && nrww_q;
    end

    // Assertions.
    assert_window_lapse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARMED && win_last && !st_req && !(reg_we && wr_legal))
            |=> (ctl_bits == '0 && !fl_valid));

    assert_illegal_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && reg_we && !wr_legal) |=> (ctl_bits == '0));

    assert_enable_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ctl_bits[0] && (ctl_bits[1] ^ ctl_bits[2])));

    assert_done_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && ctl_bits == '0));

    assert_page_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && !tmr_expired) |=> $stable(fl_page));

    assert_busy_ignores_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && !tmr_expired) |=> (!fl_valid && $stable(ctl_bits)));

    assert_stall_in_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> busy);

endmodule

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb;

    localparam int ERASE_N = 12;
    localparam int WRITE_N = 9;
    localparam int NRWW_P  = 960;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_wdata = '0;
    logic [4:0]  ctl_bits;
    logic        st_req = 1'b0;
    logic [15:0] st_ptr = '0;
    logic [15:0] st_data = '0;
    logic        fl_valid;
    logic [2:0]  fl_cmd;
    logic [9:0]  fl_page;
    logic [4:0]  fl_word;
    logic [15:0] fl_data;
    logic        busy, done, cpu_stall;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl #(
        .PAGE_WORDS   (32),
        .NRWW_PAGE    (NRWW_P),
        .ERASE_CYCLES (ERASE_N),
        .WRITE_CYCLES (WRITE_N),
        .WINDOW       (4)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .reg_we (reg_we), .reg_wdata (reg_wdata), .ctl_bits (ctl_bits),
        .st_req (st_req), .st_ptr (st_ptr), .st_data (st_data),
        .fl_valid (fl_valid), .fl_cmd (fl_cmd), .fl_page (fl_page),
        .fl_word (fl_word), .fl_data (fl_data),
        .busy (busy), .done (done), .cpu_stall (cpu_stall)
    );

    function automatic bit is_legal(input logic [4:0] p);
        return p == 5'b00001 || p == 5'b00011 || p == 5'b00101 ||
               p == 5'b01001 || p == 5'b10001;
    endfunction

    function automatic int exp_code(input logic [4:0] p);
        case (p)
            5'b00001: return 1;
            5'b00011: return 2;
            5'b00101: return 3;
            5'b01001: return 4;
            5'b10001: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic int exp_page(input logic [15:0] p);
        return int'(p[15:6]);
    endfunction

    function automatic int exp_word(input logic [15:0] p);
        return int'(p[5:1]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_reg(input logic [4:0] p);
        reg_we = 1'b1;
        reg_wdata = p;
        step();
        reg_we = 1'b0;
    endtask

    task automatic store(input logic [15:0] ptr, input logic [15:0] data);
        st_req = 1'b1;
        st_ptr = ptr;
        st_data = data;
        step();
        st_req = 1'b0;
        st_ptr = 16'($urandom);
        st_data = 16'($urandom);
    endtask

    task automatic run_busy(input int dur, input int page, input bit nrww, input logic [4:0] pat);
        int n = 0;
        while (busy && n < 200) begin
            n++;
            chk("R13 stall during op", int'(cpu_stall), int'(nrww));
            chk("R9 page held", int'(fl_page), page);
            chk((pat == 5'b00011) ? "R6 erase ctl held" : "R7 write ctl held", int'(ctl_bits), int'(pat));
            if (n > 1) chk("R12 no issue while busy", int'(fl_valid), 0);
            if (n == 2) begin
                reg_we = 1'b1;
                reg_wdata = 5'b00001;
                st_req = 1'b1;
            end else begin
                reg_we = 1'b0;
                st_req = 1'b0;
            end
            st_ptr = 16'($urandom);
            step();
        end
        reg_we = 1'b0;
        st_req = 1'b0;
        chk((pat == 5'b00011) ? "R6 erase duration" : "R7 write duration", n, dur);
        chk("R8 done pulse", int'(done), 1);
        chk("R8 ctl cleared", int'(ctl_bits), 0);
        chk("R13 stall low after", int'(cpu_stall), 0);
        step();
        chk("R8 done single cycle", int'(done), 0);
        chk("R12 busy write ignored", int'(ctl_bits), 0);
    endtask

    // Arm with pat, wait dly idle cycles, then issue a store; checks all results.
    task automatic do_op(input logic [4:0] pat, input int dly,
                         input logic [15:0] ptr, input logic [15:0] data);
        bit legal = is_legal(pat);
        bit acc;
        int code;
        write_reg(pat);
        chk(legal ? "R1 ctl shows pattern" : "R3 illegal ignored", int'(ctl_bits), legal ? int'(pat) : 0);
        repeat (dly) step();
        if (legal && dly >= 4) chk("R2 window lapsed", int'(ctl_bits), 0);
        acc = legal && dly <= 3;
        code = exp_code(pat);
        store(ptr, data);
        chk(acc ? "R1 store accepted" : (legal ? "R2 late store ignored" : "R3 store after illegal"),
            int'(fl_valid), int'(acc));
        if (!acc) return;
        chk("R1 command code", int'(fl_cmd), code);
        case (code)
            1: begin
                chk("R5 fill word", int'(fl_word), exp_word(ptr));
                chk("R5 fill page", int'(fl_page), 0);
                chk("R5 fill data", int'(fl_data), int'(data));
            end
            2, 3: begin
                chk(code == 2 ? "R6 erase data zero" : "R7 write data zero", int'(fl_data), 0);
                chk(code == 2 ? "R6 erase word zero" : "R7 write word zero", int'(fl_word), 0);
                chk("R9 page captured", int'(fl_page), exp_page(ptr));
            end
            4: begin
                chk("R10 lock page", int'(fl_page), 0);
                chk("R10 lock word", int'(fl_word), 0);
                chk("R10 lock data", int'(fl_data), int'(data));
            end
            default: begin
                chk("R11 rww fields", int'({fl_page, fl_word, fl_data}), 0);
            end
        endcase
        if (code == 2 || code == 3) begin
            chk(code == 2 ? "R6 busy" : "R7 busy", int'(busy), 1);
            run_busy(code == 2 ? ERASE_N : WRITE_N, exp_page(ptr), exp_page(ptr) >= NRWW_P, pat);
        end else begin
            chk("R5 single-cycle ctl clear", int'(ctl_bits), 0);
            chk("R5 no busy", int'(busy), 0);
            step();
            chk("R1 valid one cycle", int'(fl_valid), 0);
        end
    endtask

    initial begin
        logic [4:0] legal_pats [5] = '{5'b00001, 5'b00011, 5'b00101, 5'b01001, 5'b10001};
        void'($urandom(32'd2417));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 reset ctl", int'(ctl_bits), 0);
        chk("R8 reset busy/done", int'({busy, done}), 0);
        chk("R13 reset stall", int'(cpu_stall), 0);
        chk("R1 reset valid", int'(fl_valid), 0);

        // Window edges.
        do_op(5'b00001, 0, 16'h1234, 16'hBEEF);
        do_op(5'b00001, 3, 16'h1235, 16'hCAFE);
        do_op(5'b00001, 4, 16'h0040, 16'h1111);
        // R5 pointer bit 0 has no effect.
        do_op(5'b00001, 1, 16'h0ACF, 16'h5A5A);
        do_op(5'b00001, 1, 16'h0ACE, 16'h5A5A);
        // R3 illegal patterns while idle.
        do_op(5'b00111, 0, 16'h0100, 16'h2222);
        do_op(5'b11111, 1, 16'h0100, 16'h2222);
        // R6/R13 erase in no-read-while-write page, R7 write in other page.
        do_op(5'b00011, 2, 16'hF0C3, 16'h9999);
        do_op(5'b00101, 0, 16'h3B80, 16'h7777);
        do_op(5'b00011, 0, 16'hEFFF, 16'h0001);
        do_op(5'b00101, 1, 16'hFFFF, 16'h0002);
        // R10 lock ignores pointer, R11 re-enable.
        do_op(5'b01001, 2, 16'hFFFF, 16'h00C3);
        do_op(5'b10001, 0, 16'h4321, 16'h8888);

        // R3 illegal write while armed: window keeps original count.
        write_reg(5'b00001);
        write_reg(5'b00110);
        chk("R3 armed pattern kept", int'(ctl_bits), 1);
        step(); step();
        store(16'h0010, 16'h0F0F);
        chk("R3 window not restarted (4th edge accepted)", int'(fl_valid), 1);
        write_reg(5'b00001);
        write_reg(5'b01000);
        step(); step(); step();
        chk("R3 window lapses on original count", int'(ctl_bits), 0);

        // R4 rewrite on last edge replaces and restarts.
        write_reg(5'b00011);
        step(); step(); step();
        write_reg(5'b00001);
        chk("R4 replaced pattern", int'(ctl_bits), 1);
        step(); step(); step();
        chk("R4 window restarted", int'(ctl_bits), 1);
        store(16'h0022, 16'h1357);
        chk("R4 replaced command issued", int'(fl_cmd), 1);
        chk("R4 replaced command valid", int'(fl_valid), 1);
        chk("R4 no erase started", int'(busy), 0);

        // R4 simultaneous store and rewrite: store wins.
        write_reg(5'b00001);
        reg_we = 1'b1; reg_wdata = 5'b00011;
        store(16'h0044, 16'h2468);
        reg_we = 1'b0;
        chk("R4 store wins code", int'(fl_cmd), 1);
        chk("R4 rewrite dropped", int'(ctl_bits), 0);
        chk("R4 rewrite dropped busy", int'(busy), 0);

        // Constrained random mix.
        for (int i = 0; i < 80; i++) begin
            logic [4:0] p;
            if ($urandom % 4 != 0) p = legal_pats[$urandom % 5];
            else p = 5'($urandom);
            do_op(p, int'($urandom % 6), 16'($urandom), 16'($urandom));
            repeat ($urandom % 3) step();
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule